// File: doc/BRIEF.md
# Thresholded Channel Interrupt Arbiter

This block gathers interrupt bids from eight serial channels and picks one winner. Each channel presents three things: a 7-bit priority, a 2-bit class, and a 3-bit code. For the transmit and receive classes the code is a count code. For the "other" class it is an event type. Each channel also presents its ready byte count minus one. The winner is the eligible channel whose combined key {priority, channel number} is largest. A priority of zero means the channel is not bidding. The active-low request `irq_n` is combinational from the live winner. It goes low only when the winning priority is strictly above a programmable threshold. While a watchdog interrupt is pending, the threshold is ignored and only receiver-class channels may bid.

The host services a request in one of two ways. It runs an acknowledge cycle (`iack_start`), or it issues an update command (`upd_cmd`, which carries no data). Either one freezes the current winner into the context register `cir`. Arbitration keeps running behind the frozen context. Readbacks are derived from the frozen channel:
- an interrupt vector, which is optionally patched with the channel number and class;
- a byte-count register;
- a type register.

All pins are plain control and status signals. No data stream crosses the edge, so there is no valid/ready handshake and no back-pressure.

Top module: `chan_irq_arbiter`

## Requirements
- R1: A channel is eligible when its priority is nonzero (and, under R3, when its class is receive). The winner is the eligible channel with the largest value of priority*8 + channel. Its channel number appears in `cir[2:0]` after a load.
- R2: The threshold register takes `thr_wdata[6:0]` on `thr_we`; bit 7 is ignored. With `wdog_pending` low, `irq_n` is low exactly when the winner's priority is strictly greater than the threshold.
- R3: With `wdog_pending` high, only channels of class 2'b10 or 2'b11 are eligible. `irq_n` is low exactly when any eligible channel exists, whatever the threshold.
- R4: A cycle with `iack_start` or `upd_cmd` high loads `cir` at that clock edge. The loaded value is {class[1:0], code[2:0], channel[2:0]} of the winner. If `irq_n` is high in that cycle, the loaded value is 8'h00. Class codes: 00 other, 01 transmit, 10 receive without errors, 11 receive with errors.
- R5: Without a load, `cir` keeps its value while the bids, threshold and watchdog input change.
- R6: `vec_drive` is high in the cycle after `iack_start` and low otherwise.
- R7: `vec_out` is derived from the stored vector (written by `vec_we`) and the frozen context, according to `vec_mode`:
  - 0: the stored vector unchanged;
  - 1: bits 2:0 replaced by `cir[2:0]`;
  - 2 or 3: additionally, bits 4:3 replaced by `cir[7:6]`.
- R8: `ctx_bytes` is {4'b0, byte count minus one} of the channel in `cir[2:0]`, read live.
- R9: `ctx_type` is formed from the frozen class:
  - bit 7: the class is receive;
  - bit 6: the class is 11;
  - bit 5: the class is 01;
  - bits 4:3: zero;
  - bits 2:0: `cir[5:3]` when the class is 00, and zero otherwise.
- R10: After reset, the threshold, the stored vector and `cir` are zero, `irq_n` is high and `vec_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdog_pending | input | 1 | Watchdog interrupt pending; bypasses the threshold |
| bid_prio | input | 56 | Per-channel priority, channel n at [7n+6:7n] |
| bid_class | input | 16 | Per-channel class, channel n at [2n+1:2n] |
| bid_code | input | 24 | Per-channel count code or event type, channel n at [3n+2:3n] |
| bid_bytes | input | 32 | Per-channel ready byte count minus one, channel n at [4n+3:4n] |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | Threshold write data; bit 7 ignored |
| vec_we | input | 1 | Stored-vector write strobe |
| vec_wdata | input | 8 | Stored-vector write data |
| vec_mode | input | 2 | Vector patch mode |
| upd_cmd | input | 1 | Update command; loads the context |
| iack_start | input | 1 | Start of acknowledge cycle; loads the context |
| irq_n | output | 1 | Active-low interrupt request |
| cir | output | 8 | Frozen current-interrupt context |
| vec_drive | output | 1 | High while the vector is presented |
| vec_out | output | 8 | Patched interrupt vector |
| ctx_bytes | output | 8 | Byte count minus one of the frozen channel |
| ctx_type | output | 8 | Type readback of the frozen context |

## Verification
The hardest case to reach is a watchdog-pending load. In that case a non-receiver channel holds the largest key, yet a lower receiver must win and must still raise `irq_n` below the threshold. Random patterns reach it only rarely, so the stimulus raises `wdog_pending` in a quarter of the patterns. It also draws each priority from a mix of zero, small and full-range values, so that low-priority receivers regularly compete against higher transmit bids. A second sweep places a single bid against every threshold value to pin the strict comparison at its boundary.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER  = 2'b00,
    CLS_TX     = 2'b01,
    CLS_RX_OK  = 2'b10,
    CLS_RX_ERR = 2'b11
  } irq_class_e;

  localparam int PRIO_W  = 7;
  localparam int CODE_W  = 3;
  localparam int BYTES_W = 4;
  localparam int REG_W   = 8;
endpackage

// File: rtl/irqa_regs.sv
module irqa_regs #(
  parameter int PRIO_W = irqa_pkg::PRIO_W,
  parameter int REG_W  = irqa_pkg::REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_we,
  input  logic [PRIO_W:0]   thr_wdata,
  input  logic              vec_we,
  input  logic [REG_W-1:0]  vec_wdata,
  output logic [PRIO_W-1:0] thr,
  output logic [REG_W-1:0]  ivr
);
  // the reserved MSB of the threshold write is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr <= '0;
      ivr <= '0;
    end else begin
      if (thr_we) thr <= thr_wdata[PRIO_W-1:0];
      if (vec_we) ivr <= vec_wdata;
    end
  end
endmodule

// File: rtl/irqa_max_tree.sv
module irqa_max_tree #(
  parameter int NCH   = 8,
  parameter int KEY_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH*KEY_W-1:0] keys,
  output logic [KEY_W-1:0]     root
);
  localparam int LVL = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NP  = 1 << LVL;

  logic [KEY_W-1:0] node [2*NP-1];

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < NCH) begin : g_real
      assign node[NP-1+i] = keys[i*KEY_W +: KEY_W];
      // no eligible key may exceed the reduced winner
      p_root_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
        keys[i*KEY_W +: KEY_W] <= root);
    end else begin : g_pad
      assign node[NP-1+i] = '0;
    end
  end

  for (genvar i = 0; i < NP-1; i++) begin : g_node
    assign node[i] = (node[2*i+1] > node[2*i+2]) ? node[2*i+1] : node[2*i+2];
  end

  assign root = node[0];
endmodule

// File: rtl/irqa_context.sv
module irqa_context #(
  parameter int NCH     = 8,
  parameter int CH_W    = 3,
  parameter int CODE_W  = irqa_pkg::CODE_W,
  parameter int BYTES_W = irqa_pkg::BYTES_W,
  parameter int REG_W   = irqa_pkg::REG_W,
  localparam int CIR_W  = 2 + CODE_W + CH_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   iack_start,
  input  logic [CIR_W-1:0]       win_cir,
  input  logic [REG_W-1:0]       ivr,
  input  logic [1:0]             vec_mode,
  input  logic [NCH*BYTES_W-1:0] bid_bytes,
  output logic [CIR_W-1:0]       cir,
  output logic                   vec_drive,
  output logic [REG_W-1:0]       vec_out,
  output logic [REG_W-1:0]       ctx_bytes,
  output logic [5+CODE_W-1:0]    ctx_type
);
  import irqa_pkg::*;

  logic [CH_W-1:0]   cir_ch;
  logic [CODE_W-1:0] cir_code;
  irq_class_e        cir_cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cir       <= '0;
      vec_drive <= 1'b0;
    end else begin
      if (load) cir <= win_cir;
      vec_drive <= iack_start;
    end
  end

  assign cir_ch   = cir[CH_W-1:0];
  assign cir_code = cir[CH_W +: CODE_W];
  assign cir_cls  = irq_class_e'(cir[CIR_W-1 -: 2]);

  always_comb begin
    vec_out = ivr;
    if (vec_mode != 2'd0) vec_out[CH_W-1:0] = cir_ch;
    if (vec_mode[1])      vec_out[CH_W+1:CH_W] = cir_cls;
  end

  assign ctx_bytes = {{(REG_W-BYTES_W){1'b0}},
                      bid_bytes[int'(cir_ch)*BYTES_W +: BYTES_W]};

  assign ctx_type = {cir_cls[1], cir_cls == CLS_RX_ERR, cir_cls == CLS_TX, 2'b00,
                     (cir_cls == CLS_OTHER) ? cir_code : {CODE_W{1'b0}}};

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cir));
  p_vec_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iack_start |=> vec_drive);
endmodule

// File: rtl/chan_irq_arbiter.sv
module chan_irq_arbiter #(
  parameter int NCH     = 8,
  parameter int PRIO_W  = irqa_pkg::PRIO_W,
  parameter int CODE_W  = irqa_pkg::CODE_W,
  parameter int BYTES_W = irqa_pkg::BYTES_W,
  parameter int REG_W   = irqa_pkg::REG_W,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CIR_W  = 2 + CODE_W + CH_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wdog_pending,
  input  logic [NCH*PRIO_W-1:0]  bid_prio,
  input  logic [NCH*2-1:0]       bid_class,
  input  logic [NCH*CODE_W-1:0]  bid_code,
  input  logic [NCH*BYTES_W-1:0] bid_bytes,
  input  logic                   thr_we,
  input  logic [PRIO_W:0]        thr_wdata,
  input  logic                   vec_we,
  input  logic [REG_W-1:0]       vec_wdata,
  input  logic [1:0]             vec_mode,
  input  logic                   upd_cmd,
  input  logic                   iack_start,
  output logic                   irq_n,
  output logic [CIR_W-1:0]       cir,
  output logic                   vec_drive,
  output logic [REG_W-1:0]       vec_out,
  output logic [REG_W-1:0]       ctx_bytes,
  output logic [5+CODE_W-1:0]    ctx_type
);
  localparam int KEY_W = PRIO_W + CH_W;

  logic [PRIO_W-1:0]    thr;
  logic [REG_W-1:0]     ivr;
  logic [NCH*KEY_W-1:0] keys;
  logic [KEY_W-1:0]     root;
  logic [PRIO_W-1:0]    win_prio;
  logic [CH_W-1:0]      win_ch;
  logic [1:0]           win_cls;
  logic [CODE_W-1:0]    win_code;
  logic                 irq_req;
  logic [CIR_W-1:0]     win_cir;

  irqa_regs #(.PRIO_W(PRIO_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .vec_we(vec_we), .vec_wdata(vec_wdata), .thr(thr), .ivr(ivr)
  );

  // eligible channels present {priority, channel}; others present zero
  for (genvar g = 0; g < NCH; g++) begin : g_bid
    logic [PRIO_W-1:0] p;
    logic              rx;
    logic              elig;
    assign p    = bid_prio[g*PRIO_W +: PRIO_W];
    assign rx   = bid_class[g*2+1];
    assign elig = (p != '0) && (!wdog_pending || rx);
    assign keys[g*KEY_W +: KEY_W] = elig ? {p, CH_W'(g)} : '0;
  end

  irqa_max_tree #(.NCH(NCH), .KEY_W(KEY_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .keys(keys), .root(root)
  );

  assign win_prio = root[KEY_W-1:CH_W];
  assign win_ch   = root[CH_W-1:0];
  assign win_cls  = bid_class[int'(win_ch)*2 +: 2];
  assign win_code = bid_code[int'(win_ch)*CODE_W +: CODE_W];
  assign irq_req  = (win_prio != '0) && (wdog_pending || (win_prio > thr));
  assign win_cir  = irq_req ? {win_cls, win_code, win_ch} : '0;
  assign irq_n    = !irq_req;

  irqa_context #(.NCH(NCH), .CH_W(CH_W), .CODE_W(CODE_W), .BYTES_W(BYTES_W),
                 .REG_W(REG_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .load(upd_cmd | iack_start),
    .iack_start(iack_start), .win_cir(win_cir), .ivr(ivr),
    .vec_mode(vec_mode), .bid_bytes(bid_bytes), .cir(cir),
    .vec_drive(vec_drive), .vec_out(vec_out), .ctx_bytes(ctx_bytes),
    .ctx_type(ctx_type)
  );

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_cmd || iack_start) && irq_n |=> cir == '0);
  p_wdog_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_pending && !irq_n |-> win_cls[1]);
endmodule

// File: tb/chan_irq_arbiter_test.sv
module chan_irq_arbiter_test;
  logic clk = 0;
  logic rst_n = 0;
  logic wdog_pending = 0;
  logic [55:0] bid_prio = '0;
  logic [15:0] bid_class = '0;
  logic [23:0] bid_code = '0;
  logic [31:0] bid_bytes = '0;
  logic thr_we = 0, vec_we = 0, upd_cmd = 0, iack_start = 0;
  logic [7:0] thr_wdata = '0, vec_wdata = '0;
  logic [1:0] vec_mode = '0;
  logic irq_n, vec_drive;
  logic [7:0] cir, vec_out, ctx_bytes, ctx_type;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [6:0] m_thr = '0;
  logic [7:0] m_ivr = '0;

  always #5 clk = ~clk;

  chan_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .wdog_pending(wdog_pending), .bid_prio(bid_prio),
    .bid_class(bid_class), .bid_code(bid_code), .bid_bytes(bid_bytes),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .vec_we(vec_we), .vec_wdata(vec_wdata),
    .vec_mode(vec_mode), .upd_cmd(upd_cmd), .iack_start(iack_start), .irq_n(irq_n),
    .cir(cir), .vec_drive(vec_drive), .vec_out(vec_out), .ctx_bytes(ctx_bytes),
    .ctx_type(ctx_type)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected winner: returns {irq, cir}
  function automatic logic [8:0] model();
    int best = 0;
    logic [1:0] c;
    logic [6:0] p;
    logic req;
    for (int ch = 0; ch < 8; ch++) begin
      p = bid_prio[ch*7 +: 7];
      c = bid_class[ch*2 +: 2];
      if (p != 0 && (!wdog_pending || c[1]) && (p * 8 + ch) > best) best = p * 8 + ch;
    end
    req = (best != 0) && (wdog_pending || (best / 8) > m_thr);
    if (!req) return 9'h000;
    return {1'b1, bid_class[(best%8)*2 +: 2], bid_code[(best%8)*3 +: 3], 3'(best % 8)};
  endfunction

  task automatic write_thr(logic [7:0] d);
    @(negedge clk); thr_we = 1; thr_wdata = d;
    @(negedge clk); thr_we = 0; m_thr = d[6:0];
  endtask

  task automatic write_ivr(logic [7:0] d);
    @(negedge clk); vec_we = 1; vec_wdata = d;
    @(negedge clk); vec_we = 0; m_ivr = d;
  endtask

  function automatic logic [6:0] rnd_prio();
    int s = $urandom_range(0, 3);
    if (s == 0) return 7'd0;
    if (s == 1) return 7'($urandom_range(1, 6));
    return 7'($urandom);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] e;
    logic [7:0] v, ecir;
    logic [1:0] cls;
    bit use_iack;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset values
    chk("R10 irq_n", irq_n, 1);
    chk("R10 cir", cir, 0);
    chk("R10 vec_out", vec_out, 0);
    chk("R10 vec_drive", vec_drive, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk("R10 irq_n after release", irq_n, 1);

    // R2: reserved bit 7 of the threshold is ignored
    bid_prio = '0; bid_prio[3*7 +: 7] = 7'd1; bid_class[3*2 +: 2] = 2'b01;
    write_thr(8'h80); #1;
    chk("R2 bit7 ignored", irq_n, 0);

    // R2: strict comparison, single bid against every threshold
    for (int t = 0; t < 128; t++) begin
      write_thr(8'(t));
      for (int k = 0; k < 3; k++) begin
        logic [6:0] p = (k == 0) ? 7'(t) : (k == 1) ? 7'(t + 1) : 7'($urandom);
        bid_prio = '0; bid_prio[(t%8)*7 +: 7] = p;
        #1;
        chk("R2 threshold", irq_n, (p > 7'(t)) ? 0 : 1);
        @(negedge clk);
      end
    end

    // R1 R3 R4 R5 R6 R7 R8 R9 random patterns
    for (int n = 0; n < 1500; n++) begin
      if (n % 16 == 0) write_thr(8'($urandom));
      if (n % 50 == 0) write_ivr(8'($urandom));
      @(negedge clk);
      for (int ch = 0; ch < 8; ch++) begin
        bid_prio[ch*7 +: 7] = rnd_prio();
        bid_class[ch*2 +: 2] = 2'($urandom);
        bid_code[ch*3 +: 3] = 3'($urandom);
        bid_bytes[ch*4 +: 4] = 4'($urandom);
      end
      wdog_pending = ($urandom_range(0, 3) == 0);
      vec_mode = 2'($urandom);
      #1;
      e = model();
      chk(wdog_pending ? "R3 irq_n" : "R2 irq_n", irq_n, !e[8]);
      use_iack = n[0];
      @(negedge clk);
      if (use_iack) iack_start = 1; else upd_cmd = 1;
      @(negedge clk);
      iack_start = 0; upd_cmd = 0;
      #1;
      ecir = e[7:0];
      chk("R1 channel", cir[2:0], ecir[2:0]);
      chk("R4 cir", cir, ecir);
      chk("R6 vec_drive", vec_drive, use_iack);
      cls = ecir[7:6];
      v = m_ivr;
      if (vec_mode != 0) v[2:0] = ecir[2:0];
      if (vec_mode >= 2) v[4:3] = cls;
      chk("R7 vec_out", vec_out, v);
      chk("R8 ctx_bytes", ctx_bytes, {4'b0, bid_bytes[ecir[2:0]*4 +: 4]});
      chk("R9 ctx_type", ctx_type,
          {cls[1], cls == 2'b11, cls == 2'b01, 2'b00, (cls == 2'b00) ? ecir[5:3] : 3'b000});
      // R5: disturb everything without a load
      for (int ch = 0; ch < 8; ch++) bid_prio[ch*7 +: 7] = rnd_prio();
      bid_class = 16'($urandom);
      wdog_pending = ~wdog_pending;
      @(negedge clk); @(negedge clk); #1;
      chk("R5 hold", cir, ecir);
      chk("R6 vec_drive low", vec_drive, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule